// File: doc/BRIEF.md
# Boot Partition Firmware Command Handler

This block executes the two administrative commands that maintain a storage controller's boot partitions. One loads image data into a staging buffer. The other commits that data into a partition or selects which partition is active. A command arrives already decoded, as an 8-bit opcode and two 32-bit command dwords, and is accepted when `cmd_valid` and `cmd_ready` are both high. Every accepted command ends in exactly one completion pulse. The pulse carries an 11-bit status, formed as a 3-bit status type above an 8-bit code, and a separate do-not-retry flag.

For a download that fits inside the staging buffer, the block issues a one-cycle write request to the external staging memory, with a byte offset and a byte length. For a commit, the block checks the requested action in a fixed priority order. The activate action updates the active-partition bit at once. The replace action raises a copy request to the external partition storage. Its completion is held back until that storage reports that the copy is done or that it failed. No further command is accepted while a copy is pending.

Top module: `bpfw_cmd_unit`

## Requirements
- R1: During and after reset, `cmd_ready` is 1, `active_part` is 0, and `cpl_valid`, `stage_wr_valid` and `copy_req` are 0.
- R2: Opcode 0x10 is the commit command. In its dword 10, bits 2:0 are the slot, bits 5:3 are the action and bit 31 is the partition ID. A commit with a nonzero slot, or with action 0, completes on the cycle after acceptance with status 0x106 and DNR set.
- R3: A commit with slot 0 and action 1 to 5 completes on the cycle after acceptance with status 0x113 and DNR set.
- R4: A commit with slot 0 and action 7 completes on the next cycle with status 0x000 and DNR clear. From that same cycle, `active_part` equals the partition-ID bit of the command.
- R5: A commit with slot 0 and action 6 raises `copy_req` on the next cycle and holds it until `copy_done` or `copy_err` is sampled high. During the request, `copy_offset` stays stable: it is 0 for partition 0 and `PART_BYTES` for partition 1.
- R6: A copy ends with a completion on the cycle after `copy_done` or `copy_err` is sampled. The status is 0x000 on done and 0x280 on error, DNR is clear, and `copy_req` drops on that same cycle. If both inputs are high together, the error wins.
- R7: Opcode 0x11 is the download command. Dword 10 is a zero-based dword count and dword 11 is a dword offset. When 4·offset + 4·(count+1) ≤ `PART_BYTES`, the next cycle carries a success completion and a `stage_wr_valid` pulse with offset 4·offset and length 4·(count+1). The exact-fit case is accepted.
- R8: A download that ends beyond `PART_BYTES` completes with status 0x002 and DNR set, and issues no staging write.
- R9: Any other opcode completes with status 0x001 and DNR set, and has no other effect.
- R10: While a copy is pending, `cmd_ready` is 0 and a presented command is neither accepted nor executed.
- R11: A rejected commit (status 0x106 or 0x113) leaves `active_part` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_opcode | input | 8 | Admin opcode |
| cmd_dw10 | input | 32 | Command dword 10 |
| cmd_dw11 | input | 32 | Command dword 11 |
| stage_wr_valid | output | 1 | One-cycle staging-buffer write request |
| stage_wr_offset | output | ADDR_W | Staging byte offset |
| stage_wr_len | output | ADDR_W | Staging byte length |
| copy_req | output | 1 | Copy staging buffer into a partition |
| copy_offset | output | ADDR_W | Partition storage byte offset of the copy |
| copy_done | input | 1 | Copy finished successfully |
| copy_err | input | 1 | Copy failed |
| active_part | output | 1 | Active partition ID |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_status | output | 11 | Status type and code |
| cpl_dnr | output | 1 | Do-not-retry flag |

## Verification
Most errors inside this block show up one cycle after acceptance, because each command except replace completes on the next cycle.

- **Check order:** If the priority between the slot check and the action check is wrong, a commit carrying both faults reports the wrong status.
- **Download sum:** If the sum is wrongly sized or compared, the exact-fit download is refused, or an overrun download is let through.
- **Pending flag:** If the pending flag is stuck or dropped early, a completion is lost or arrives too soon. It also lets a command slip in during a copy, which shows as an unexpected completion or a flipped `active_part` one cycle later.

// File: rtl/bpfw_pkg.sv
package bpfw_pkg;

    localparam int STATUS_W = 11;

    localparam logic [7:0] OPC_COMMIT   = 8'h10;
    localparam logic [7:0] OPC_DOWNLOAD = 8'h11;

    localparam logic [STATUS_W-1:0] ST_SUCCESS     = 11'h000;
    localparam logic [STATUS_W-1:0] ST_INV_OPCODE  = 11'h001;
    localparam logic [STATUS_W-1:0] ST_INV_FIELD   = 11'h002;
    localparam logic [STATUS_W-1:0] ST_INV_SLOT    = 11'h106;
    localparam logic [STATUS_W-1:0] ST_ACT_PROHIB  = 11'h113;
    localparam logic [STATUS_W-1:0] ST_WRITE_FAULT = 11'h280;

    localparam logic [2:0] ACT_REPLACE_PART  = 3'd6;
    localparam logic [2:0] ACT_ACTIVATE_PART = 3'd7;

    typedef enum logic [1:0] {
        K_DOWNLOAD,
        K_COMMIT,
        K_OTHER
    } cmd_kind_e;

    typedef enum logic [1:0] {
        CV_BAD_SLOT,
        CV_PROHIBITED,
        CV_ACTIVATE,
        CV_REPLACE
    } commit_verdict_e;

    typedef struct packed {
        logic [2:0]  slot;
        logic [2:0]  action;
        logic        part_id;
        logic [31:0] dw_count;
        logic [31:0] dw_offset;
    } cmd_fields_t;

endpackage

// File: rtl/bpfw_decode.sv
module bpfw_decode
    import bpfw_pkg::*;
(
    input  logic [7:0]  opcode,
    input  logic [31:0] dw10,
    input  logic [31:0] dw11,
    output cmd_kind_e   kind,
    output cmd_fields_t fields
);
    always_comb begin
        unique case (opcode)
            OPC_DOWNLOAD: kind = K_DOWNLOAD;
            OPC_COMMIT:   kind = K_COMMIT;
            default:      kind = K_OTHER;
        endcase
        fields.slot      = dw10[2:0];
        fields.action    = dw10[5:3];
        fields.part_id   = dw10[31];
        fields.dw_count  = dw10;
        fields.dw_offset = dw11;
    end
endmodule

// File: rtl/bpfw_dl_check.sv
module bpfw_dl_check #(
    parameter int PART_BYTES = 131072,
    parameter int ADDR_W     = $clog2(PART_BYTES) + 1
) (
    input  logic [31:0]       dw_count,
    input  logic [31:0]       dw_offset,
    output logic              fits,
    output logic [ADDR_W-1:0] byte_ofs,
    output logic [ADDR_W-1:0] byte_len
);
    localparam int SUM_W = 36;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(PART_BYTES);

    logic [SUM_W-1:0] len_b;
    logic [SUM_W-1:0] ofs_b;
    logic [SUM_W-1:0] end_b;

    always_comb begin
        len_b    = ({4'b0, dw_count} + SUM_W'(1)) << 2;
        ofs_b    = {2'b0, dw_offset, 2'b00};
        end_b    = len_b + ofs_b;
        fits     = (end_b <= LIMIT);
        byte_ofs = ofs_b[ADDR_W-1:0];
        byte_len = len_b[ADDR_W-1:0];
    end
endmodule

// File: rtl/bpfw_commit_eval.sv
module bpfw_commit_eval
    import bpfw_pkg::*;
(
    input  logic [2:0]      slot,
    input  logic [2:0]      action,
    output commit_verdict_e verdict
);
    always_comb begin
        if (slot != 3'd0 || action == 3'd0)
            verdict = CV_BAD_SLOT;
        else if (action < ACT_REPLACE_PART)
            verdict = CV_PROHIBITED;
        else if (action == ACT_ACTIVATE_PART)
            verdict = CV_ACTIVATE;
        else
            verdict = CV_REPLACE;
    end
endmodule

// File: rtl/bpfw_cmd_unit.sv
module bpfw_cmd_unit
    import bpfw_pkg::*;
#(
    parameter int PART_BYTES = 131072,
    parameter int ADDR_W     = $clog2(PART_BYTES) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [7:0]          cmd_opcode,
    input  logic [31:0]         cmd_dw10,
    input  logic [31:0]         cmd_dw11,
    output logic                stage_wr_valid,
    output logic [ADDR_W-1:0]   stage_wr_offset,
    output logic [ADDR_W-1:0]   stage_wr_len,
    output logic                copy_req,
    output logic [ADDR_W-1:0]   copy_offset,
    input  logic                copy_done,
    input  logic                copy_err,
    output logic                active_part,
    output logic                cpl_valid,
    output logic [STATUS_W-1:0] cpl_status,
    output logic                cpl_dnr
);
    localparam logic [ADDR_W-1:0] PART1_BASE = ADDR_W'(PART_BYTES);

    typedef struct packed {
        logic                pending;
        logic [ADDR_W-1:0]   copy_ofs;
        logic                active;
        logic                cpl_valid;
        logic [STATUS_W-1:0] status;
        logic                dnr;
        logic                stage_valid;
        logic [ADDR_W-1:0]   stage_ofs;
        logic [ADDR_W-1:0]   stage_len;
    } state_t;

    state_t st_d, st_q;

    cmd_kind_e       kind;
    cmd_fields_t     fields;
    commit_verdict_e verdict;
    logic            dl_fits;
    logic [ADDR_W-1:0] dl_ofs, dl_len;

    bpfw_decode u_decode (
        .opcode (cmd_opcode),
        .dw10   (cmd_dw10),
        .dw11   (cmd_dw11),
        .kind   (kind),
        .fields (fields)
    );

    bpfw_dl_check #(.PART_BYTES(PART_BYTES), .ADDR_W(ADDR_W)) u_dl_check (
        .dw_count  (fields.dw_count),
        .dw_offset (fields.dw_offset),
        .fits      (dl_fits),
        .byte_ofs  (dl_ofs),
        .byte_len  (dl_len)
    );

    bpfw_commit_eval u_commit_eval (
        .slot    (fields.slot),
        .action  (fields.action),
        .verdict (verdict)
    );

    always_comb begin
        st_d             = st_q;
        st_d.cpl_valid   = 1'b0;
        st_d.stage_valid = 1'b0;
        if (st_q.pending) begin
            if (copy_done || copy_err) begin
                st_d.pending   = 1'b0;
                st_d.cpl_valid = 1'b1;
                st_d.status    = copy_err ? ST_WRITE_FAULT : ST_SUCCESS;
                st_d.dnr       = 1'b0;
            end
        end else if (cmd_valid) begin
            st_d.cpl_valid = 1'b1;
            st_d.dnr       = 1'b1;
            unique case (kind)
                K_DOWNLOAD: begin
                    if (dl_fits) begin
                        st_d.status      = ST_SUCCESS;
                        st_d.dnr         = 1'b0;
                        st_d.stage_valid = 1'b1;
                        st_d.stage_ofs   = dl_ofs;
                        st_d.stage_len   = dl_len;
                    end else begin
                        st_d.status = ST_INV_FIELD;
                    end
                end
                K_COMMIT: begin
                    unique case (verdict)
                        CV_BAD_SLOT:   st_d.status = ST_INV_SLOT;
                        CV_PROHIBITED: st_d.status = ST_ACT_PROHIB;
                        CV_ACTIVATE: begin
                            st_d.status = ST_SUCCESS;
                            st_d.dnr    = 1'b0;
                            st_d.active = fields.part_id;
                        end
                        CV_REPLACE: begin
                            st_d.cpl_valid = 1'b0;
                            st_d.dnr       = 1'b0;
                            st_d.pending   = 1'b1;
                            st_d.copy_ofs  = fields.part_id ? PART1_BASE : '0;
                        end
                        default: st_d.status = ST_INV_SLOT;
                    endcase
                end
                default: st_d.status = ST_INV_OPCODE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_ready       = !st_q.pending;
    assign copy_req        = st_q.pending;
    assign copy_offset     = st_q.copy_ofs;
    assign active_part     = st_q.active;
    assign cpl_valid       = st_q.cpl_valid;
    assign cpl_status      = st_q.status;
    assign cpl_dnr         = st_q.dnr;
    assign stage_wr_valid  = st_q.stage_valid;
    assign stage_wr_offset = st_q.stage_ofs;
    assign stage_wr_len    = st_q.stage_len;

    AST_REJECT_HAS_DNR: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && (cpl_status == ST_INV_SLOT || cpl_status == ST_ACT_PROHIB ||
                      cpl_status == ST_INV_FIELD || cpl_status == ST_INV_OPCODE) |-> cpl_dnr); // R2
    AST_COPY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req |-> !cmd_ready); // R10
    AST_COPY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req && !copy_done && !copy_err |=> copy_req); // R5
    AST_COPY_OFS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req && $past(copy_req) |-> $stable(copy_offset)); // R5
    AST_COPY_ENDS_IN_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req && (copy_done || copy_err) |=> cpl_valid && !copy_req); // R6
    AST_STAGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        stage_wr_valid |-> ({1'b0, stage_wr_offset} + {1'b0, stage_wr_len}) <= (ADDR_W+1)'(PART_BYTES)); // R7
    AST_STAGE_WITH_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        stage_wr_valid |-> cpl_valid && cpl_status == ST_SUCCESS); // R7
    AST_ACTIVE_ONLY_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        active_part != $past(active_part) |-> cpl_valid && cpl_status == ST_SUCCESS); // R11
endmodule

// File: tb/bpfw_cmd_unit_tb.sv
`timescale 1ns/1ps
module bpfw_cmd_unit_tb_top;
    localparam int PB = 131072;
    localparam int AW = $clog2(PB) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [7:0] cmd_opcode = 8'h0;
    logic [31:0] cmd_dw10 = 32'h0, cmd_dw11 = 32'h0;
    logic stage_wr_valid;
    logic [AW-1:0] stage_wr_offset, stage_wr_len;
    logic copy_req;
    logic [AW-1:0] copy_offset;
    logic copy_done = 1'b0, copy_err = 1'b0;
    logic active_part;
    logic cpl_valid;
    logic [10:0] cpl_status;
    logic cpl_dnr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bpfw_cmd_unit #(.PART_BYTES(PB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_opcode(cmd_opcode), .cmd_dw10(cmd_dw10), .cmd_dw11(cmd_dw11),
        .stage_wr_valid(stage_wr_valid), .stage_wr_offset(stage_wr_offset),
        .stage_wr_len(stage_wr_len), .copy_req(copy_req), .copy_offset(copy_offset),
        .copy_done(copy_done), .copy_err(copy_err), .active_part(active_part),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_dnr(cpl_dnr)
    );

    typedef struct packed {
        logic [3:0]    req;
        logic [7:0]    opc;
        logic [31:0]   dw10;
        logic [31:0]   dw11;
        logic [10:0]   status;
        logic          dnr;
        logic          stage;
        logic [AW-1:0] ofs;
        logic [AW-1:0] len;
        logic          active;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd7,  8'h11, 32'h0,        32'h0,     11'h000, 1'b0, 1'b1, 18'd0,      18'd4,      1'b0}, // R7 one dword
        '{4'd7,  8'h11, 32'd1023,     32'd256,   11'h000, 1'b0, 1'b1, 18'd1024,   18'd4096,   1'b0}, // R7
        '{4'd7,  8'h11, 32'd32767,    32'h0,     11'h000, 1'b0, 1'b1, 18'd0,      18'd131072, 1'b0}, // R7 exact fit
        '{4'd7,  8'h11, 32'h0,        32'd32767, 11'h000, 1'b0, 1'b1, 18'd131068, 18'd4,      1'b0}, // R7 last dword
        '{4'd8,  8'h11, 32'h0,        32'd32768, 11'h002, 1'b1, 1'b0, 18'd0,      18'd0,      1'b0}, // R8 one past
        '{4'd8,  8'h11, 32'hFFFFFFFF, 32'h0,     11'h002, 1'b1, 1'b0, 18'd0,      18'd0,      1'b0}, // R8 huge count
        '{4'd2,  8'h10, 32'h00000031, 32'h0,     11'h106, 1'b1, 1'b0, 18'd0,      18'd0,      1'b0}, // R2 slot beats action
        '{4'd2,  8'h10, 32'h00000000, 32'h0,     11'h106, 1'b1, 1'b0, 18'd0,      18'd0,      1'b0}, // R2 action 0
        '{4'd3,  8'h10, 32'h00000008, 32'h0,     11'h113, 1'b1, 1'b0, 18'd0,      18'd0,      1'b0}, // R3 action 1
        '{4'd3,  8'h10, 32'h00000028, 32'h0,     11'h113, 1'b1, 1'b0, 18'd0,      18'd0,      1'b0}, // R3 action 5
        '{4'd4,  8'h10, 32'h80000038, 32'h0,     11'h000, 1'b0, 1'b0, 18'd0,      18'd0,      1'b1}, // R4 activate 1
        '{4'd11, 8'h10, 32'h0000003A, 32'h0,     11'h106, 1'b1, 1'b0, 18'd0,      18'd0,      1'b1}, // R11 bad slot
        '{4'd11, 8'h10, 32'h00000018, 32'h0,     11'h113, 1'b1, 1'b0, 18'd0,      18'd0,      1'b1}, // R11 prohibited
        '{4'd9,  8'h06, 32'h80000038, 32'h0,     11'h001, 1'b1, 1'b0, 18'd0,      18'd0,      1'b1}, // R9 other opcode
        '{4'd4,  8'h10, 32'h00000038, 32'h0,     11'h000, 1'b0, 1'b0, 18'd0,      18'd0,      1'b0}  // R4 activate 0
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] opc, input logic [31:0] d10, input logic [31:0] d11);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = opc; cmd_dw10 = d10; cmd_dw11 = d11;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 64'(cmd_ready), 64'd1);
        chk("R1 cpl in reset", 64'(cpl_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", 64'(cmd_ready), 64'd1);
        chk("R1 active", 64'(active_part), 64'd0);
        chk("R1 copy_req", 64'(copy_req), 64'd0);
        chk("R1 stage", 64'(stage_wr_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            string t;
            issue(VECS[i].opc, VECS[i].dw10, VECS[i].dw11);
            t = $sformatf("R%0d vec%0d", VECS[i].req, i);
            chk({t, " cpl"}, 64'(cpl_valid), 64'd1);
            chk({t, " status"}, 64'(cpl_status), 64'(VECS[i].status));
            chk({t, " dnr"}, 64'(cpl_dnr), 64'(VECS[i].dnr));
            chk({t, " stage"}, 64'(stage_wr_valid), 64'(VECS[i].stage));
            if (VECS[i].stage) begin
                chk({t, " ofs"}, 64'(stage_wr_offset), 64'(VECS[i].ofs));
                chk({t, " len"}, 64'(stage_wr_len), 64'(VECS[i].len));
            end
            chk({t, " active"}, 64'(active_part), 64'(VECS[i].active));
            chk({t, " no copy"}, 64'(copy_req), 64'd0);
        end

        // R5 replace into partition 0, stalled by storage
        issue(8'h10, 32'h00000030, 32'h0);
        chk("R5 copy_req", 64'(copy_req), 64'd1);
        chk("R5 copy_offset p0", 64'(copy_offset), 64'd0);
        chk("R5 no early cpl", 64'(cpl_valid), 64'd0);
        chk("R10 ready low", 64'(cmd_ready), 64'd0);
        // R10 activate presented while pending must not execute
        issue(8'h10, 32'h80000038, 32'h0);
        chk("R10 no cpl", 64'(cpl_valid), 64'd0);
        @(negedge clk);
        chk("R10 active unchanged", 64'(active_part), 64'd0);
        chk("R5 still requesting", 64'(copy_req), 64'd1);
        copy_done = 1'b1;
        @(negedge clk);
        copy_done = 1'b0;
        chk("R6 done cpl", 64'(cpl_valid), 64'd1);
        chk("R6 done status", 64'(cpl_status), 64'h000);
        chk("R6 done dnr", 64'(cpl_dnr), 64'd0);
        chk("R6 req dropped", 64'(copy_req), 64'd0);
        chk("R6 ready back", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        chk("R6 single pulse", 64'(cpl_valid), 64'd0);

        // R5 replace into partition 1, failing
        issue(8'h10, 32'h80000030, 32'h0);
        chk("R5 copy_offset p1", 64'(copy_offset), 64'(PB));
        copy_err = 1'b1; copy_done = 1'b1;
        @(negedge clk);
        copy_err = 1'b0; copy_done = 1'b0;
        chk("R6 err cpl", 64'(cpl_valid), 64'd1);
        chk("R6 err status", 64'(cpl_status), 64'h280);
        chk("R6 err dnr", 64'(cpl_dnr), 64'd0);
        chk("R5 replace keeps active", 64'(active_part), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule